// File: doc/BRIEF.md
# Chainable Serial RGB PWM Driver

This block receives colour data over a two-wire serial link (a clock line and a data line) and drives three pulse-width-modulated outputs, one for each of the red, green and blue LED strings. Each device keeps the first 24 bits of a frame. It splits them into three 8-bit intensity values. Every bit after the 24th is re-driven on a forwarding clock/data pair, so several devices can sit in a chain on one link. Each device takes its own 24 bits and passes the rest downstream.

A frame ends when the serial clock stays low for a set number of system clock cycles. At that point the captured intensities move into the duty registers and the bit counter rearms for the next frame. The host only talks to the chain when a colour has to change. Between updates the PWM generators keep running from the stored duties.

Both serial inputs pass through a two-flop synchronizer into the system clock domain. Bits are taken on the detected rising edge of the synchronized serial clock.

Top module: `chain_rgb_pwm`

## Requirements
- R1: After a synchronous active-high reset, every output (`pwm_o`, `fwd_clk_o`, `fwd_dat_o`) is low and all three duties are zero, so no PWM output goes high until a frame is committed.
- R2: Bits are sampled on the serial clock rising edge, most significant bit first. The first 8 bits set the duty of `pwm_o[2]` (red), the next 8 set `pwm_o[1]` (green) and the last 8 set `pwm_o[0]` (blue).
- R3: A channel with duty D is high for exactly D cycles out of every 256 consecutive system clock cycles. D = 0 is never high and D = 255 is high 255 of 256 cycles.
- R4: Each serial bit after the 24th of a frame produces exactly one rising edge on `fwd_clk_o`. `fwd_dat_o` carries that bit, is set at least one cycle before the forwarded rising edge and holds steady while `fwd_clk_o` is high.
- R5: During the first 24 bits of a frame `fwd_clk_o` stays low.
- R6: Captured values take effect only after the serial clock has been low for IDLE_CYCLES system clock cycles. Until then the previous duties stay in force.
- R7: A frame that ends with fewer than 24 bits leaves the duties unchanged. The bit counter still restarts, so the next full frame is captured correctly.
- R8: With no serial traffic the duties and the PWM waveforms persist indefinitely.
- R9: Bits forwarded downstream never alter this device's own duties.
- R10: After a commit the bit counter restarts. The first 24 bits of the next frame are captured locally and none of them is forwarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial link clock from the host or the upstream device |
| ser_dat_i | input | 1 | Serial link data |
| fwd_clk_o | output | 1 | Re-driven serial clock for the downstream device |
| fwd_dat_o | output | 1 | Re-driven serial data for the downstream device |
| pwm_o | output | 3 | PWM outputs: bit 2 red, bit 1 green, bit 0 blue |

## Verification
The bench measures duty by counting high cycles over a full 256-cycle window. It uses the extremes 0, 1, 128 and 255, so an off-by-one compare (`<=` instead of `<`) shows up as 1 and 256 instead of 0 and 255. It checks the duties before the idle window has expired. A design that commits early, or that commits on every 24th bit, shows the new colour too soon. A short frame followed by idle must leave the colour alone and must not shift the next frame's alignment. A design that commits partial data or does not clear the counter misreads the following frame. A chained frame of 40 bits must keep the first 24 and forward exactly 16 bits in order. A design that forwards a clock pulse on the 24th bit, or changes data while the forwarded clock is high, fails the captured-bit comparison or the stability count.

// File: rtl/rgbpwm_pkg.sv
package rgbpwm_pkg;
  localparam int DEF_CHANNELS  = 3;
  localparam int DEF_DUTY_W    = 8;
  localparam int DEF_IDLE      = 50000;  // 500 us at a 100 MHz system clock
  localparam int DEF_SYNC_DEPTH = 2;

  function automatic int frame_bits(input int channels, input int duty_w);
    return channels * duty_w;
  endfunction
endpackage

// File: rtl/sig_sync.sv
module sig_sync #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [DEPTH-1:0] stage;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage[0] <= 1'b0;
          else     stage[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage[g] <= 1'b0;
          else     stage[g] <= stage[g-1];
        end
      end
    end
  endgenerate

  assign q = stage[DEPTH-1];
endmodule

// File: rtl/frame_rx.sv
module frame_rx #(
  parameter int CHANNELS    = 3,
  parameter int DUTY_W      = 8,
  parameter int IDLE_CYCLES = 50000
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         sclk_s,
  input  logic                         sdat_s,
  output logic [CHANNELS*DUTY_W-1:0]   duty_flat,
  output logic                         fwd_clk_o,
  output logic                         fwd_dat_o,
  output logic                         commit_o
);
  localparam int FRAME  = rgbpwm_pkg::frame_bits(CHANNELS, DUTY_W);
  localparam int CNT_W  = $clog2(FRAME + 1);
  localparam int IDLE_W = $clog2(IDLE_CYCLES + 1);
  localparam logic [CNT_W-1:0]  FULL_CNT  = CNT_W'(FRAME);
  localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(IDLE_CYCLES - 1);
  localparam logic [IDLE_W-1:0] IDLE_SAT  = IDLE_W'(IDLE_CYCLES);

  logic              sclk_q;
  logic              rise, fall, full, idle_fire;
  logic [CNT_W-1:0]  bit_cnt;
  logic [FRAME-1:0]  shreg;
  logic [IDLE_W-1:0] idle_cnt;
  logic              fwd_hi;

  assign rise      = sclk_s & ~sclk_q;
  assign fall      = ~sclk_s & sclk_q;
  assign full      = (bit_cnt == FULL_CNT);
  assign idle_fire = ~sclk_s & (idle_cnt == IDLE_LAST);

  // Edge history and idle timer
  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q   <= 1'b0;
      idle_cnt <= '0;
    end else begin
      sclk_q <= sclk_s;
      if (sclk_s)                  idle_cnt <= '0;
      else if (idle_cnt != IDLE_SAT) idle_cnt <= idle_cnt + 1'b1;
    end
  end

  // Capture, forwarding and commit
  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt   <= '0;
      shreg     <= '0;
      duty_flat <= '0;
      fwd_hi    <= 1'b0;
      fwd_dat_o <= 1'b0;
      fwd_clk_o <= 1'b0;
      commit_o  <= 1'b0;
    end else begin
      commit_o  <= 1'b0;
      fwd_clk_o <= fwd_hi;
      if (rise) begin
        if (!full) begin
          shreg   <= {shreg[FRAME-2:0], sdat_s};
          bit_cnt <= bit_cnt + 1'b1;
        end else begin
          fwd_dat_o <= sdat_s;
          fwd_hi    <= 1'b1;
        end
      end
      if (fall) fwd_hi <= 1'b0;
      if (idle_fire) begin
        if (full) duty_flat <= shreg;
        bit_cnt   <= '0;
        fwd_dat_o <= 1'b0;
        commit_o  <= 1'b1;
      end
    end
  end

  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= FULL_CNT);
  p_fwd_only_full_r5: assert property (@(posedge clk) disable iff (rst)
    fwd_clk_o |-> full);
  p_fwd_dat_hold_r4: assert property (@(posedge clk) disable iff (rst)
    fwd_clk_o |-> $stable(fwd_dat_o));
  p_duty_on_commit_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(duty_flat) |-> commit_o);
  p_restart_r10: assert property (@(posedge clk) disable iff (rst)
    commit_o |-> (bit_cnt == '0) && !sclk_s);
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DUTY_W-1:0] tick,
  input  logic [DUTY_W-1:0] duty,
  output logic              pwm_o
);
  always_ff @(posedge clk) begin
    if (rst) pwm_o <= 1'b0;
    else     pwm_o <= (tick < duty);
  end

  p_zero_off_r3: assert property (@(posedge clk) disable iff (rst)
    (duty == '0) |=> !pwm_o);
endmodule

// File: rtl/chain_rgb_pwm.sv
module chain_rgb_pwm #(
  parameter int CHANNELS    = rgbpwm_pkg::DEF_CHANNELS,
  parameter int DUTY_W      = rgbpwm_pkg::DEF_DUTY_W,
  parameter int IDLE_CYCLES = rgbpwm_pkg::DEF_IDLE,
  parameter int SYNC_DEPTH  = rgbpwm_pkg::DEF_SYNC_DEPTH
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ser_clk_i,
  input  logic                ser_dat_i,
  output logic                fwd_clk_o,
  output logic                fwd_dat_o,
  output logic [CHANNELS-1:0] pwm_o
);
  logic                       sclk_s, sdat_s, commit;
  logic [CHANNELS*DUTY_W-1:0] duty_flat;
  logic [DUTY_W-1:0]          tick;

  sig_sync #(.DEPTH(SYNC_DEPTH)) i_sync_clk (
    .clk(clk), .rst(rst), .d(ser_clk_i), .q(sclk_s));
  sig_sync #(.DEPTH(SYNC_DEPTH)) i_sync_dat (
    .clk(clk), .rst(rst), .d(ser_dat_i), .q(sdat_s));

  frame_rx #(.CHANNELS(CHANNELS), .DUTY_W(DUTY_W), .IDLE_CYCLES(IDLE_CYCLES)) i_rx (
    .clk(clk), .rst(rst), .sclk_s(sclk_s), .sdat_s(sdat_s),
    .duty_flat(duty_flat), .fwd_clk_o(fwd_clk_o), .fwd_dat_o(fwd_dat_o),
    .commit_o(commit));

  // Shared free-running PWM timebase
  always_ff @(posedge clk) begin
    if (rst) tick <= '0;
    else     tick <= tick + 1'b1;
  end

  genvar k;
  generate
    for (k = 0; k < CHANNELS; k++) begin : g_chan
      pwm_chan #(.DUTY_W(DUTY_W)) i_chan (
        .clk(clk), .rst(rst), .tick(tick),
        .duty(duty_flat[k*DUTY_W +: DUTY_W]), .pwm_o(pwm_o[k]));
    end
  endgenerate

  p_quiet_after_commit_r8: assert property (@(posedge clk) disable iff (rst)
    commit |=> !fwd_clk_o);
endmodule

// File: tb/test_chain_rgb_pwm.sv
module test_chain_rgb_pwm;
  localparam int IDLE = 600;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0;
  logic sdi = 1'b0;
  logic fwd_clk, fwd_dat;
  logic [2:0] pwm;

  int n_cmp = 0;
  int n_bad = 0;
  int fwd_rises = 0;
  int fwd_unstable = 0;
  logic [63:0] fwd_bits = '0;
  logic prev_fclk = 1'b0;
  logic prev_fdat = 1'b0;
  int cnt_r, cnt_g, cnt_b;

  always #2 clk = ~clk;

  chain_rgb_pwm #(.IDLE_CYCLES(IDLE)) i_chain_rgb_pwm (
    .clk(clk), .rst(rst), .ser_clk_i(sck), .ser_dat_i(sdi),
    .fwd_clk_o(fwd_clk), .fwd_dat_o(fwd_dat), .pwm_o(pwm));

  // Downstream monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (fwd_clk && !prev_fclk) begin
        fwd_rises <= fwd_rises + 1;
        fwd_bits  <= {fwd_bits[62:0], fwd_dat};
      end
      if (fwd_clk && prev_fclk && fwd_dat != prev_fdat)
        fwd_unstable <= fwd_unstable + 1;
    end
    prev_fclk <= fwd_clk;
    prev_fdat <= fwd_dat;
  end

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [63:0] data, input int nbits);
    for (int i = nbits - 1; i >= 0; i--) begin
      @(negedge clk); sdi = data[i]; sck = 1'b0;
      repeat (3) @(negedge clk);
      sck = 1'b1;
      repeat (4) @(negedge clk);
    end
    @(negedge clk); sck = 1'b0; sdi = 1'b0;
  endtask

  task automatic measure();
    cnt_r = 0; cnt_g = 0; cnt_b = 0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      cnt_r += int'(pwm[2]); cnt_g += int'(pwm[1]); cnt_b += int'(pwm[0]);
    end
  endtask

  task automatic clear_mon();
    @(negedge clk);
    fwd_rises = 0; fwd_unstable = 0; fwd_bits = '0;
  endtask

  task automatic expect_rgb(input string req, input int r, input int g, input int b);
    measure();
    check({req, " red"}, cnt_r, r);
    check({req, " green"}, cnt_g, g);
    check({req, " blue"}, cnt_b, b);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 pwm", int'(pwm), 0);
    check("R1 fwd_clk", int'(fwd_clk), 0);
    check("R1 fwd_dat", int'(fwd_dat), 0);
    expect_rgb("R1", 0, 0, 0);
  endtask

  task automatic t_basic();
    clear_mon();
    send(64'h80_01_FF, 24);
    repeat (IDLE + 20) @(negedge clk);
    expect_rgb("R2/R3", 128, 1, 255);
    check("R5 no forward in 24 bits", fwd_rises, 0);
  endtask

  task automatic t_idle_window();
    send(64'h10_20_30, 24);
    repeat (10) @(negedge clk);
    expect_rgb("R6 before idle", 128, 1, 255);
    repeat (IDLE) @(negedge clk);
    expect_rgb("R6 after idle", 16, 32, 48);
  endtask

  task automatic t_partial();
    send(64'h3FF, 10);
    repeat (IDLE + 20) @(negedge clk);
    expect_rgb("R7 partial kept", 16, 32, 48);
    send(64'h05_A0_7E, 24);
    repeat (IDLE + 20) @(negedge clk);
    expect_rgb("R7 realign", 5, 160, 126);
  endtask

  task automatic t_chain();
    clear_mon();
    send(64'h40_41_42_B5C3, 40);
    repeat (IDLE + 20) @(negedge clk);
    expect_rgb("R9 own duty", 64, 65, 66);
    check("R4 forward count", fwd_rises, 16);
    check("R4 forward data", int'(fwd_bits[15:0]), 16'hB5C3);
    check("R4 data stable", fwd_unstable, 0);
  endtask

  task automatic t_restart();
    clear_mon();
    send(64'h00_FF_00, 24);
    repeat (IDLE + 20) @(negedge clk);
    check("R10 no forward after commit", fwd_rises, 0);
    expect_rgb("R10/R3 extremes", 0, 255, 0);
  endtask

  task automatic t_hold();
    repeat (3000) @(negedge clk);
    expect_rgb("R8 hold", 0, 255, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_idle_window();
    t_partial();
    t_chain();
    t_restart();
    t_hold();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule